// File: doc/BRIEF.md
# Synchronous Burst SRAM with Dual Address Strobes

This block is a clocked static RAM whose word is split into two independently writable halves. Each half holds eight data bits and one parity bit. All control inputs are sampled on the rising clock edge. Two active-low address strobes load a new base address. One strobe belongs to the processor and the other to the cache controller. Chip select gates both strobes, with different rules for each, and the processor strobe wins when both are low on the same edge.

After an address is loaded, a two-bit burst offset generator steps through the four words of the aligned group each time the advance input is sampled low. A parameter selects the step order: linear (wrap modulo 4) or interleaved (start XOR step). Read data is registered and follows the current pointer one clock after it changes. The bus drive enables react to the output enable without waiting for a clock. The data bus is split into input, output and a per-half drive enable, so that the tristate buffer sits at the pad.

The default address width is kept small so that elaboration stays light. Set `ADDR_W` to 16 for a 64K-word array.

Top module: `burst_sram`

## Requirements
- R1: While and after reset, until the first strobe edge with chip select low, the device is deselected and `data_drv` is 2'b00.
- R2: A cache strobe (`ctl_stb_n` low) with `cs_n` low loads `addr_i` as the pointer. `data_o` shows the addressed word after that same edge. The word layout is {hi half = bits 17:9, lo half = bits 8:0}.
- R3: When both strobes are low with `cs_n` low, only the processor strobe is acted on. The address is loaded and any requested write is dropped.
- R4: With `cs_n` high, the processor strobe is ignored. The pointer is not reloaded, selection is unchanged, and a write requested on that edge goes to the current pointer.
- R5: `ctl_stb_n` low with `cs_n` high deselects the device. While deselected, writes are dropped and `data_drv` stays 2'b00 until a strobe edge with `cs_n` low.
- R6: `wr_n[1]` low writes the hi half (bits 17:9) and `wr_n[0]` low writes the lo half (bits 8:0) from `data_i`. The target is the loaded address on a strobe edge and the current pointer otherwise. The other half is left unchanged.
- R7: On an edge where `cpu_stb_n` and `cs_n` are both low, both write enables are ignored.
- R8: `data_drv[h]` is 1 only when all four conditions hold: `oe_n` is low (combinationally, no clock), `cs_n` was low at the last edge, the device is selected, and `wr_n[h]` was high at the last edge.
- R9: In linear mode (`INTERLEAVED`=0), each edge with `adv_n` low and no address load moves the pointer's low two bits to (start + k) mod 4.
- R10: In interleaved mode (`INTERLEAVED`=1), each advance moves the pointer's low two bits to start XOR k, where k is the number of advances since the load.
- R11: On an edge that loads an address, `adv_n` is ignored and the burst restarts at the loaded low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Word address, loaded on a strobe edge |
| cpu_stb_n | input | 1 | Processor address strobe, active low |
| ctl_stb_n | input | 1 | Cache-controller address strobe, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 2 | Half write enables, active low: bit 1 hi, bit 0 lo |
| adv_n | input | 1 | Burst advance, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| data_i | input | 2*HALF_W | Write data |
| data_o | output | 2*HALF_W | Registered read data |
| data_drv | output | 2 | Per-half bus drive enable |

## Verification
The bench builds two copies with `ADDR_W`=4, a 16-word array. One copy is linear and one is interleaved, and both get the same stimulus. This size lets every word be filled and read back. Every start offset of a burst can be walked in both orders, and the strobe, chip-select and write-enable combinations can be applied to known contents and compared against an arithmetic data pattern.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int HALVES = 2;

  typedef struct packed {
    logic strobe;
    logic capture;
    logic sel_next;
    logic [HALVES-1:0] we;
  } strobe_ctl_t;
endpackage

// File: rtl/burst_offset_gen.sv
module burst_offset_gen #(
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [1:0] start_in,
  input  logic       adv,
  output logic [1:0] offset,
  output logic [1:0] offset_nxt
);
  logic [1:0] start_q, step_q, start_d, step_d;

  always_comb begin
    start_d = start_q;
    step_d  = step_q;
    if (load) begin
      start_d = start_in;
      step_d  = 2'd0;
    end else if (adv) begin
      step_d = 2'(step_q + 2'd1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 2'd0;
      step_q  <= 2'd0;
    end else begin
      start_q <= start_d;
      step_q  <= step_d;
    end
  end

  generate
    if (INTERLEAVED) begin : g_xor
      assign offset     = start_q ^ step_q;
      assign offset_nxt = start_d ^ step_d;

      p_adv_moves_r10: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (offset != $past(offset)));
    end else begin : g_lin
      assign offset     = 2'(start_q + step_q);
      assign offset_nxt = 2'(start_d + step_d);

      p_adv_step_r9: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> (offset == 2'($past(offset) + 2'd1)));
    end
  endgenerate

  p_load_restart_r11: assert property (@(posedge clk) disable iff (rst)
    load |=> (offset == $past(start_in)));
endmodule

// File: rtl/strobe_decode.sv
module strobe_decode
  import burst_sram_pkg::*;
(
  input  logic              cpu_stb_n,
  input  logic              ctl_stb_n,
  input  logic              cs_n,
  input  logic [HALVES-1:0] wr_n,
  input  logic              selected,
  output strobe_ctl_t       ctl
);
  logic cpu_act;

  always_comb begin
    cpu_act     = !cpu_stb_n && !cs_n;
    ctl.strobe  = cpu_act || !ctl_stb_n;
    ctl.capture = ctl.strobe && !cs_n;
    ctl.sel_next = ctl.strobe ? !cs_n : selected;
    for (int h = 0; h < HALVES; h++)
      ctl.we[h] = ctl.sel_next && !wr_n[h] && !cpu_act;
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int HALF_W      = 9,
  parameter bit INTERLEAVED = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  cpu_stb_n,
  input  logic                  ctl_stb_n,
  input  logic                  cs_n,
  input  logic [1:0]            wr_n,
  input  logic                  adv_n,
  input  logic                  oe_n,
  input  logic [2*HALF_W-1:0]   data_i,
  output logic [2*HALF_W-1:0]   data_o,
  output logic [1:0]            data_drv
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int BASE_W = ADDR_W - 2;

  strobe_ctl_t         sc;
  logic                selected_q, cs_q;
  logic [1:0]          wr_seen_q;
  logic [BASE_W-1:0]   base_q, base_d;
  logic [1:0]          offset, offset_nxt;
  logic [ADDR_W-1:0]   ptr, ptr_nxt, wr_addr;

  strobe_decode u_dec (
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .selected  (selected_q),
    .ctl       (sc)
  );

  burst_offset_gen #(.INTERLEAVED(INTERLEAVED)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .load       (sc.capture),
    .start_in   (addr_i[1:0]),
    .adv        (!adv_n && !sc.capture),
    .offset     (offset),
    .offset_nxt (offset_nxt)
  );

  assign base_d  = sc.capture ? addr_i[ADDR_W-1:2] : base_q;
  assign ptr     = {base_q, offset};
  assign ptr_nxt = {base_d, offset_nxt};
  assign wr_addr = sc.capture ? addr_i : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q     <= '0;
      selected_q <= 1'b0;
      cs_q       <= 1'b0;
      wr_seen_q  <= 2'b00;
    end else begin
      base_q     <= base_d;
      selected_q <= sc.sel_next;
      cs_q       <= !cs_n;
      wr_seen_q  <= ~wr_n;
    end
  end

  generate
    for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] mem [DEPTH];
      logic [HALF_W-1:0] rd_q;

      always_ff @(posedge clk) begin
        if (sc.we[h])
          mem[wr_addr] <= data_i[h*HALF_W +: HALF_W];
        rd_q <= mem[ptr_nxt];
      end

      assign data_o[h*HALF_W +: HALF_W] = rd_q;
      assign data_drv[h] = !oe_n && cs_q && selected_q && !wr_seen_q[h];
    end
  endgenerate

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (data_drv == 2'b00));

  p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctl_stb_n && cs_n) |=> (data_drv == 2'b00));

  p_hold_ptr_r4: assert property (@(posedge clk) disable iff (rst)
    (!cpu_stb_n && cs_n && ctl_stb_n && adv_n) |=> $stable(ptr));

  p_drive_needs_oe_r8: assert property (@(posedge clk) disable iff (rst)
    (data_drv != 2'b00) |-> !oe_n);

  p_load_ptr_r2: assert property (@(posedge clk) disable iff (rst)
    (!ctl_stb_n && !cs_n) |=> (ptr == $past(addr_i)));
endmodule

// File: tb/test_burst_sram.sv
module test_burst_sram;
  localparam int AW = 4;
  localparam int HW = 9;
  localparam int DW = 2 * HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic cpu_stb_n = 1'b1, ctl_stb_n = 1'b1, cs_n = 1'b0, adv_n = 1'b1, oe_n = 1'b0;
  logic [1:0] wr_n = 2'b11;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] dout_il, dout_ln;
  logic [1:0] drv_il, drv_ln;

  int total = 0;
  int bad = 0;
  logic [DW-1:0] m [16];

  always #5 clk = ~clk;

  burst_sram #(.ADDR_W(AW), .HALF_W(HW), .INTERLEAVED(1'b1)) i_burst_sram (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .cs_n(cs_n), .wr_n(wr_n), .adv_n(adv_n),
    .oe_n(oe_n), .data_i(data_i), .data_o(dout_il), .data_drv(drv_il));

  burst_sram #(.ADDR_W(AW), .HALF_W(HW), .INTERLEAVED(1'b0)) i_burst_sram_lin (
    .clk(clk), .rst(rst), .addr_i(addr_i), .cpu_stb_n(cpu_stb_n),
    .ctl_stb_n(ctl_stb_n), .cs_n(cs_n), .wr_n(wr_n), .adv_n(adv_n),
    .oe_n(oe_n), .data_i(data_i), .data_o(dout_ln), .data_drv(drv_ln));

  function automatic logic [DW-1:0] pat(input int a);
    return DW'(a * 4111 + 677);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; cs_n = 1'b0; wr_n = 2'b11; adv_n = 1'b1;
  endtask

  task automatic load(input int a);
    idle(); ctl_stb_n = 1'b0; addr_i = AW'(a);
  endtask

  task automatic chk_both(input string req, input logic [DW-1:0] exp);
    chk(req, dout_il, exp);
    chk(req, dout_ln, exp);
  endtask

  task automatic chk_drv(input string req, input logic [1:0] exp);
    chk(req, DW'(drv_il), DW'(exp));
    chk(req, DW'(drv_ln), DW'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk_drv("R1 drive during reset", 2'b00);
    rst = 1'b0;
    tick(); tick();
    chk_drv("R1 drive after reset, no strobe", 2'b00);

    // R6: fill every word through cache-strobe write cycles
    for (int a = 0; a < 16; a++) begin
      load(a); wr_n = 2'b00; data_i = pat(a);
      tick();
      m[a] = pat(a);
    end
    idle(); tick();

    // R2 / R8: read sweep with async output enable
    for (int a = 0; a < 16; a++) begin
      load(a); tick();
      chk_both("R2 read after load", m[a]);
      chk_drv("R8 drive when enabled", 2'b11);
      oe_n = 1'b1; #1;
      chk_drv("R8 oe high releases bus", 2'b00);
      oe_n = 1'b0; #1;
      chk_drv("R8 oe low restores drive", 2'b11);
    end

    // R9 / R10 / R11: bursts from every start offset in both orders
    for (int g = 0; g < 2; g++) begin
      for (int s = 0; s < 4; s++) begin
        load(g * 8 + 4 + s); adv_n = 1'b0;
        tick();
        chk_both("R11 adv ignored on load", m[g * 8 + 4 + s]);
        idle(); adv_n = 1'b0;
        for (int k = 1; k < 6; k++) begin
          tick();
          chk("R10 interleaved step", dout_il, m[g * 8 + 4 + (s ^ (k % 4))]);
          chk("R9 linear step", dout_ln, m[g * 8 + 4 + ((s + k) % 4)]);
        end
        idle();
      end
    end

    // R6: hi-half only, then lo-half only
    load(3); wr_n = 2'b01; data_i = 18'h2AAAA;
    tick();
    m[3][17:9] = data_i[17:9];
    chk_drv("R8 hi half released after hi write", 2'b01);
    idle(); tick();
    chk_both("R6 hi half write", m[3]);
    load(3); wr_n = 2'b10; data_i = 18'h15555;
    tick();
    m[3][8:0] = data_i[8:0];
    chk_drv("R8 lo half released after lo write", 2'b10);
    idle(); tick();
    chk_both("R6 lo half write", m[3]);

    // R7: processor strobe with chip select drops the write
    idle(); cpu_stb_n = 1'b0; addr_i = 4'd5; wr_n = 2'b00; data_i = 18'h3FFFF;
    tick();
    idle(); tick();
    chk_both("R7 write dropped on processor strobe", m[5]);

    // R3: both strobes low, processor wins
    idle(); cpu_stb_n = 1'b0; ctl_stb_n = 1'b0; addr_i = 4'd6; wr_n = 2'b00; data_i = 18'h00001;
    tick();
    idle(); tick();
    chk_both("R3 both strobes: load, no write", m[6]);

    // R4: processor strobe with chip select high is ignored
    load(8); tick();
    idle(); cpu_stb_n = 1'b0; cs_n = 1'b1; addr_i = 4'd9; wr_n = 2'b10; data_i = 18'h0_0123;
    tick();
    chk_both("R4 no reload, pointer kept", m[8]);
    chk_drv("R8 chip select high at last edge", 2'b00);
    m[8][8:0] = data_i[8:0];
    idle(); tick();
    chk_both("R4 write to current pointer", m[8]);
    chk_drv("R4 still selected", 2'b11);

    // R5: deselect, dropped write, reselect
    idle(); ctl_stb_n = 1'b0; cs_n = 1'b1; addr_i = 4'd2;
    tick();
    chk_drv("R5 deselected drive", 2'b00);
    idle(); wr_n = 2'b00; data_i = 18'h1FFFF;
    tick();
    chk_drv("R5 deselected drive with cs low", 2'b00);
    idle(); tick();
    chk_drv("R5 still deselected", 2'b00);
    load(8); tick();
    chk_both("R5 write dropped while deselected", m[8]);
    chk_drv("R5 reselected drive", 2'b11);
    idle(); tick();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule